// File: doc/BRIEF.md
# Spin-Wait Callback Directory

This block is a small, fully associative directory that sits next to a shared last-level cache. It serves only the loads and stores that take part in spin-waiting, and it tracks them one word at a time. It holds a few entries, four by default, and serves a fixed set of cores, also four by default. For each tracked word an entry records two bits per core. The full/empty bit shows that a value is waiting for that core. The callback bit shows that the core is parked until the word is next written. A waiting reader therefore sleeps in the directory and does not keep re-reading the cache.

The block accepts one request per cycle. A request carries an operation code, a core id, a word address and write data. A small internal word store stands in for the last-level cache. Each core has its own response lane, which holds a valid bit and a data word. A lane carries either the immediate answer to that core's own request or a delayed wake-up sent when a write or an eviction releases the core. There are three kinds of write: one wakes every waiter, one wakes a single waiter in turn, and one wakes nobody. The single-waiter write also switches the entry into a mode where the full/empty bits behave as one shared bit. Entries are never saved when they are evicted. Any core still waiting on an evicted entry is released with the word's current value.

Top module: `spin_cbdir`

## Requirements
- R1: After a synchronous reset, every `rsp_valid` lane is low and the directory holds no entries. A response lane is high for exactly one cycle, in the cycle that follows the request or the write that causes it.
- R2: A plain read (op 0) returns the stored word on the requester's lane one cycle later, and only on that lane. A wake-all write (op 4) to an address with no entry only updates the word store. Neither operation ever allocates an entry.
- R3: A callback read (op 2) that misses allocates an entry. The new entry starts with every full/empty bit full, no callbacks set and all-mode. The read is therefore answered at once with the current word and the requester's bit becomes empty. A second callback read from the same core gets no response and sets that core's callback bit.
- R4: A wake-all write (op 4) to a tracked address does four things. It sends the new value to every core whose callback bit is set and clears those callback bits. It leaves the woken cores empty. It sets every other core's full/empty bit to full. It returns the entry to all-mode.
- R5: A no-wake write (op 5) updates the word and produces no responses. It changes neither the full/empty bits nor the callback bits, so a parked core stays parked until a later write.
- R6: A wake-one write (op 6) to a tracked address puts the entry in one-mode. It wakes exactly one parked core with the new value. The choice is round-robin, starting at the core after the one last served on that entry; a fresh entry starts from core 0. The shared full/empty state is left empty.
- R7: A wake-one write with no parked core sets the shared state to full. The next callback read from any core consumes that value, and a callback read from a second core then parks.
- R8: In one-mode a plain read or a wake-all write returns the entry to all-mode. After that the full/empty bits act per core again.
- R9: A non-blocking load (op 1) always returns the current word one cycle later, even when the requester's bit is already empty. If the bit is full, the load consumes it, so a following callback read from that core parks. The load never allocates an entry.
- R10: When a callback read misses and every entry is valid, the least recently used entry is evicted. In the same cycle as the requester's own answer, every core parked on the evicted address receives that address's current word. A later callback read to the evicted address allocates a fresh entry and is answered at once.
- R11: Op codes 3 and 7, and any cycle with `req_valid` low, produce no response and change neither the word store nor the directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 plain read, 1 non-blocking load, 2 callback read, 4 wake-all write, 5 no-wake write, 6 wake-one write |
| req_core | input | CW ($clog2(NCORES)) | Requesting core |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | NCORES | One response strobe per core, bit i for core i |
| rsp_data | output | NCORES*DW | Response words, core i in bits [i*DW +: DW] |

## Verification
The hardest state to reach is an eviction in which the least recently used entry still has a parked core. The directory must first be filled with three other addresses, and none of the steps in between may touch the victim again. The stimulus first parks one core on an address. It then refreshes a second tracked address with a plain read, installs two new addresses with callback reads, and issues a plain read and write to a fifth address, checking that these do not evict anything. Only then does a callback read to that fifth address force the eviction, and the bench checks that both lanes respond in the same cycle. The round-robin wrap of the wake-one write is reached by parking all four cores, releasing two, re-parking the first one served, and releasing three more.

// File: rtl/spin_cbdir_pkg.sv
`timescale 1ns/1ps
package spin_cbdir_pkg;
  typedef logic [2:0] op_t;
  localparam op_t OP_RD      = 3'd0;  // plain read
  localparam op_t OP_RD_NB   = 3'd1;  // non-blocking consuming load
  localparam op_t OP_RD_CB   = 3'd2;  // callback read
  localparam op_t OP_WR_ALL  = 3'd4;  // write, wake every waiter
  localparam op_t OP_WR_NONE = 3'd5;  // write, wake nobody
  localparam op_t OP_WR_ONE  = 3'd6;  // write, wake one waiter

  function automatic logic is_write(input op_t op);
    return (op == OP_WR_ALL) || (op == OP_WR_NONE) || (op == OP_WR_ONE);
  endfunction
endpackage

// File: rtl/spin_cbdir_match.sv
`timescale 1ns/1ps
module spin_cbdir_match #(
  parameter int NE = 4,
  parameter int AW = 8,
  localparam int IW = $clog2(NE)
) (
  input  logic [NE-1:0]         valid,
  input  logic [NE-1:0][AW-1:0] tags,
  input  logic [AW-1:0]         addr,
  output logic                  hit,
  output logic [IW-1:0]         hit_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NE; i++) begin
      if (valid[i] && tags[i] == addr) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spin_cbdir_lru.sv
`timescale 1ns/1ps
module spin_cbdir_lru #(
  parameter int NE = 4,
  localparam int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] valid,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // Ages form a permutation of 0..NE-1; 0 is the most recent.
  logic [NE-1:0][IW-1:0] age_q;

  for (genvar g = 0; g < NE; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[g] <= IW'(g);
      end else if (touch_en) begin
        if (touch_idx == IW'(g))
          age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx])
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    if (&valid) begin
      for (int i = 0; i < NE; i++)
        if (age_q[i] == IW'(NE - 1)) victim_idx = IW'(i);
    end else begin
      for (int i = NE - 1; i >= 0; i--)
        if (!valid[i]) victim_idx = IW'(i);
    end
  end
endmodule

// File: rtl/spin_cbdir_rr.sv
`timescale 1ns/1ps
module spin_cbdir_rr #(
  parameter int NC = 4,
  localparam int CW = $clog2(NC)
) (
  input  logic [NC-1:0] req,
  input  logic [CW-1:0] last,
  output logic          found,
  output logic [CW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NC; k++) begin
      automatic int j = (int'(last) + k) % NC;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = CW'(j);
      end
    end
  end
endmodule

// File: rtl/spin_cbdir_words.sv
`timescale 1ns/1ps
module spin_cbdir_words #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spin_cbdir.sv
`timescale 1ns/1ps
module spin_cbdir
  import spin_cbdir_pkg::*;
#(
  parameter int NCORES   = 4,
  parameter int NENTRIES = 4,
  parameter int AW       = 8,
  parameter int DW       = 32,
  localparam int CW = $clog2(NCORES),
  localparam int IW = $clog2(NENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [CW-1:0]        req_core,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic [NCORES-1:0]    rsp_valid,
  output logic [NCORES*DW-1:0] rsp_data
);
  // directory state
  logic [NENTRIES-1:0]              val_q, val_d;
  logic [NENTRIES-1:0][AW-1:0]      tag_q, tag_d;
  logic [NENTRIES-1:0][NCORES-1:0]  fe_q, fe_d;
  logic [NENTRIES-1:0][NCORES-1:0]  cb_q, cb_d;
  logic [NENTRIES-1:0]              one_q, one_d;
  logic [NENTRIES-1:0][CW-1:0]      rrl_q, rrl_d;

  // response registers
  logic [NCORES-1:0]                rv_q, rv_d;
  logic [NCORES-1:0][DW-1:0]        rd_q, rd_d;

  logic                hit;
  logic [IW-1:0]       hit_idx, vic_idx, touch_idx;
  logic                touch_en;
  logic [DW-1:0]       word_req, word_vic;
  logic                mem_we;
  logic                rr_found;
  logic [CW-1:0]       rr_pick;
  logic [NCORES-1:0]   core_oh;

  spin_cbdir_match #(.NE(NENTRIES), .AW(AW)) u_match (
    .valid(val_q), .tags(tag_q), .addr(req_addr),
    .hit(hit), .hit_idx(hit_idx)
  );

  spin_cbdir_lru #(.NE(NENTRIES)) u_lru (
    .clk(clk), .rst(rst), .valid(val_q),
    .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(vic_idx)
  );

  spin_cbdir_rr #(.NC(NCORES)) u_rr (
    .req(cb_q[hit_idx]), .last(rrl_q[hit_idx]),
    .found(rr_found), .pick(rr_pick)
  );

  spin_cbdir_words #(.AW(AW), .DW(DW)) u_words (
    .clk(clk), .we(mem_we), .waddr(req_addr), .wdata(req_wdata),
    .raddr_a(req_addr), .rdata_a(word_req),
    .raddr_b(tag_q[vic_idx]), .rdata_b(word_vic)
  );

  assign core_oh = NCORES'(1) << req_core;
  assign mem_we  = req_valid && is_write(req_op);

  always_comb begin
    val_d = val_q;  tag_d = tag_q;  fe_d = fe_q;  cb_d = cb_q;
    one_d = one_q;  rrl_d = rrl_q;
    rv_d  = '0;     rd_d  = rd_q;
    touch_en  = 1'b0;
    touch_idx = hit_idx;

    if (req_valid) begin
      case (req_op)
        OP_RD: begin
          rv_d[req_core] = 1'b1;
          rd_d[req_core] = word_req;
          if (hit) begin
            one_d[hit_idx] = 1'b0;
            touch_en       = 1'b1;
          end
        end

        OP_RD_NB: begin
          rv_d[req_core] = 1'b1;
          rd_d[req_core] = word_req;
          if (hit) begin
            if (one_q[hit_idx]) fe_d[hit_idx] = '0;
            else                fe_d[hit_idx][req_core] = 1'b0;
            touch_en = 1'b1;
          end
        end

        OP_RD_CB: begin
          touch_en = 1'b1;
          if (hit) begin
            if (fe_q[hit_idx][req_core]) begin
              rv_d[req_core] = 1'b1;
              rd_d[req_core] = word_req;
              if (one_q[hit_idx]) fe_d[hit_idx] = '0;
              else                fe_d[hit_idx][req_core] = 1'b0;
            end else begin
              cb_d[hit_idx][req_core] = 1'b1;
            end
          end else begin
            // release cores parked on the victim with its current word
            if (val_q[vic_idx]) begin
              for (int i = 0; i < NCORES; i++) begin
                if (cb_q[vic_idx][i]) begin
                  rv_d[i] = 1'b1;
                  rd_d[i] = word_vic;
                end
              end
            end
            touch_idx      = vic_idx;
            val_d[vic_idx] = 1'b1;
            tag_d[vic_idx] = req_addr;
            fe_d[vic_idx]  = ~core_oh;
            cb_d[vic_idx]  = '0;
            one_d[vic_idx] = 1'b0;
            rrl_d[vic_idx] = CW'(NCORES - 1);
            rv_d[req_core] = 1'b1;
            rd_d[req_core] = word_req;
          end
        end

        OP_WR_ALL: begin
          if (hit) begin
            touch_en = 1'b1;
            for (int i = 0; i < NCORES; i++) begin
              if (cb_q[hit_idx][i]) begin
                rv_d[i] = 1'b1;
                rd_d[i] = req_wdata;
              end else begin
                fe_d[hit_idx][i] = 1'b1;
              end
            end
            cb_d[hit_idx]  = '0;
            one_d[hit_idx] = 1'b0;
          end
        end

        OP_WR_NONE: begin
          if (hit) touch_en = 1'b1;
        end

        OP_WR_ONE: begin
          if (hit) begin
            touch_en       = 1'b1;
            one_d[hit_idx] = 1'b1;
            if (rr_found) begin
              rv_d[rr_pick]           = 1'b1;
              rd_d[rr_pick]           = req_wdata;
              cb_d[hit_idx][rr_pick]  = 1'b0;
              rrl_d[hit_idx]          = rr_pick;
              fe_d[hit_idx]           = '0;
            end else begin
              fe_d[hit_idx] = '1;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      tag_q <= '0;
      fe_q  <= '0;
      cb_q  <= '0;
      one_q <= '0;
      rrl_q <= '0;
      rv_q  <= '0;
      rd_q  <= '0;
    end else begin
      val_q <= val_d;
      tag_q <= tag_d;
      fe_q  <= fe_d;
      cb_q  <= cb_d;
      one_q <= one_d;
      rrl_q <= rrl_d;
      rv_q  <= rv_d;
      rd_q  <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
endmodule

// File: rtl/spin_cbdir_chk.sv
`timescale 1ns/1ps
module spin_cbdir_chk #(
  parameter int NC = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [CW-1:0] req_core,
  input logic [NC-1:0] rsp_valid
);
  logic [NC-1:0] req_oh;
  assign req_oh = NC'(1) << req_core;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> rsp_valid == '0);                                          // R1

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (|rsp_valid) |-> $past(req_valid));                                // R1

  AST_PLAIN_READ_LANE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd0 |=> rsp_valid == $past(req_oh));       // R2

  AST_NB_READ_LANE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd1 |=> rsp_valid == $past(req_oh));       // R9

  AST_NOWAKE_SILENT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd5 |=> rsp_valid == '0);                  // R5

  AST_WAKE_ONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd6 |=> $onehot0(rsp_valid));              // R6

  AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_op == 3'd3 || req_op == 3'd7) |=> rsp_valid == '0); // R11
endmodule

bind spin_cbdir spin_cbdir_chk #(.NC(NCORES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_core(req_core), .rsp_valid(rsp_valid)
);

// File: tb/test_spin_cbdir.sv
`timescale 1ns/1ps
module test_spin_cbdir;
  localparam logic [2:0] RD = 3'd0, NB = 3'd1, CB = 3'd2,
                         WA = 3'd4, W0 = 3'd5, W1 = 3'd6;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [1:0]  req_core;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  rsp_valid;
  logic [127:0] rsp_data;

  logic [3:0]   got_v;
  logic [127:0] got_d;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spin_cbdir i_spin_cbdir (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected <100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic [2:0] op, input int core,
                       input logic [7:0] addr, input logic [31:0] d);
    req_valid = v; req_op = op; req_core = core[1:0];
    req_addr = addr; req_wdata = d;
    @(negedge clk);
    got_v = rsp_valid;
    got_d = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input int core,
                       input logic [7:0] addr, input logic [31:0] d);
    drive(1'b1, op, core, addr, d);
  endtask

  task automatic chk_v(input string tag, input logic [3:0] exp);
    checks++;
    if (got_v !== exp) begin
      errors++;
      $display("FAIL %s: rsp_valid=%b expected %b", tag, got_v, exp);
    end
  endtask

  task automatic chk_d(input string tag, input int core, input logic [31:0] exp);
    checks++;
    if (got_d[core*32 +: 32] !== exp) begin
      errors++;
      $display("FAIL %s: lane%0d data=%h expected %h", tag, core, got_d[core*32 +: 32], exp);
    end
  endtask

  task automatic t_reset;
    got_v = rsp_valid;
    chk_v("R1 reset lanes low", 4'b0000);
  endtask

  task automatic t_alloc;
    issue(WA, 3, 8'h10, 32'hA1);
    chk_v("R2 untracked write silent", 4'b0000);
    issue(CB, 0, 8'h10, 0);
    chk_v("R3 first callback immediate", 4'b0001);
    chk_d("R3 first callback data", 0, 32'hA1);
    drive(1'b0, RD, 0, 8'h10, 0);
    chk_v("R1 response lasts one cycle", 4'b0000);
    issue(CB, 0, 8'h10, 0);
    chk_v("R3 second callback parks", 4'b0000);
    issue(CB, 1, 8'h10, 0);
    chk_v("R3 other core still full", 4'b0010);
    issue(CB, 1, 8'h10, 0);
    chk_v("R3 core1 parks", 4'b0000);
  endtask

  task automatic t_wake_all;
    issue(WA, 2, 8'h10, 32'hB0);
    chk_v("R4 wake both waiters", 4'b0011);
    chk_d("R4 lane0 new value", 0, 32'hB0);
    chk_d("R4 lane1 new value", 1, 32'hB0);
    issue(CB, 2, 8'h10, 0);
    chk_v("R4 non-waiter set full", 4'b0100);
    chk_d("R4 non-waiter data", 2, 32'hB0);
    issue(CB, 0, 8'h10, 0);
    chk_v("R4 woken core stays empty", 4'b0000);
    issue(WA, 3, 8'h10, 32'hB2);
    chk_v("R4 release core0", 4'b0001);
  endtask

  task automatic t_nowake;
    issue(CB, 0, 8'h10, 0);
    chk_v("R5 core0 parks", 4'b0000);
    issue(W0, 3, 8'h10, 32'hC0);
    chk_v("R5 no-wake write silent", 4'b0000);
    issue(RD, 3, 8'h10, 0);
    chk_v("R2 plain read lane", 4'b1000);
    chk_d("R5 word updated", 3, 32'hC0);
    issue(WA, 3, 8'h10, 32'hD0);
    chk_v("R5 parked until later write", 4'b0001);
    chk_d("R5 later write data", 0, 32'hD0);
  endtask

  task automatic t_wake_one;
    issue(WA, 3, 8'h20, 32'hE0);
    for (int c = 0; c < 4; c++) begin
      issue(CB, c, 8'h20, 0);
      chk_v("R3 fresh entry full for each core", 4'b0001 << c);
    end
    for (int c = 0; c < 4; c++) begin
      issue(CB, c, 8'h20, 0);
      chk_v("R3 all cores park", 4'b0000);
    end
    issue(W1, 3, 8'h20, 32'hF1);
    chk_v("R6 first wake core0", 4'b0001);
    chk_d("R6 wake data", 0, 32'hF1);
    issue(W1, 3, 8'h20, 32'hF2);
    chk_v("R6 next wake core1", 4'b0010);
    issue(CB, 0, 8'h20, 0);
    chk_v("R6 shared empty parks core0", 4'b0000);
    issue(W1, 3, 8'h20, 32'hF3);
    chk_v("R6 next wake core2", 4'b0100);
    issue(W1, 3, 8'h20, 32'hF4);
    chk_v("R6 next wake core3", 4'b1000);
    issue(W1, 3, 8'h20, 32'hF5);
    chk_v("R6 wrap to core0", 4'b0001);
    issue(W1, 3, 8'h20, 32'hF6);
    chk_v("R7 no waiter silent", 4'b0000);
    issue(CB, 2, 8'h20, 0);
    chk_v("R7 any core consumes", 4'b0100);
    chk_d("R7 consumed data", 2, 32'hF6);
    issue(CB, 1, 8'h20, 0);
    chk_v("R7 second core parks", 4'b0000);
    issue(W1, 3, 8'h20, 32'hF7);
    chk_v("R6 wake core1 after core0", 4'b0010);
  endtask

  task automatic t_mode;
    issue(W1, 3, 8'h20, 32'hF8);
    chk_v("R7 shared full", 4'b0000);
    issue(RD, 3, 8'h20, 0);
    chk_d("R8 plain read data", 3, 32'hF8);
    issue(CB, 0, 8'h20, 0);
    chk_v("R8 core0 consumes", 4'b0001);
    issue(CB, 1, 8'h20, 0);
    chk_v("R8 per-core bits again", 4'b0010);
    issue(CB, 1, 8'h20, 0);
    chk_v("R8 core1 parks", 4'b0000);
    issue(WA, 3, 8'h20, 32'hF9);
    chk_v("R4 release core1", 4'b0010);
  endtask

  task automatic t_nb;
    issue(NB, 0, 8'h20, 0);
    chk_v("R9 nb immediate", 4'b0001);
    chk_d("R9 nb data", 0, 32'hF9);
    issue(NB, 0, 8'h20, 0);
    chk_v("R9 nb when empty", 4'b0001);
    chk_d("R9 nb data again", 0, 32'hF9);
    issue(CB, 0, 8'h20, 0);
    chk_v("R9 nb consumed, callback parks", 4'b0000);
    issue(WA, 3, 8'h20, 32'hFA);
    chk_v("R9 release core0", 4'b0001);
  endtask

  task automatic t_evict;
    issue(CB, 1, 8'h10, 0);
    chk_v("R10 core1 consumes D0", 4'b0010);
    issue(CB, 1, 8'h10, 0);
    chk_v("R10 core1 parks on 0x10", 4'b0000);
    issue(RD, 2, 8'h20, 0);
    issue(WA, 3, 8'h30, 32'h30);
    issue(WA, 3, 8'h40, 32'h40);
    issue(CB, 3, 8'h30, 0);
    chk_v("R10 alloc 0x30", 4'b1000);
    issue(CB, 3, 8'h40, 0);
    chk_v("R10 alloc 0x40", 4'b1000);
    issue(WA, 2, 8'h50, 32'h50);
    chk_v("R2 write to 0x50 no evict", 4'b0000);
    issue(RD, 0, 8'h50, 0);
    chk_v("R2 plain read no evict", 4'b0001);
    chk_d("R2 plain read data", 0, 32'h50);
    issue(CB, 0, 8'h50, 0);
    chk_v("R10 eviction releases waiter", 4'b0011);
    chk_d("R10 requester data", 0, 32'h50);
    chk_d("R10 evicted word", 1, 32'hD0);
    issue(CB, 1, 8'h10, 0);
    chk_v("R10 realloc immediate", 4'b0010);
    chk_d("R10 realloc data", 1, 32'hD0);
  endtask

  task automatic t_ignored;
    issue(3'd3, 0, 8'h50, 32'hDEAD);
    chk_v("R11 op3 silent", 4'b0000);
    issue(3'd7, 0, 8'h50, 32'hDEAD);
    chk_v("R11 op7 silent", 4'b0000);
    drive(1'b0, WA, 0, 8'h50, 32'hBEEF);
    chk_v("R11 invalid cycle silent", 4'b0000);
    issue(RD, 2, 8'h50, 0);
    chk_d("R11 word unchanged", 2, 32'h50);
    issue(CB, 2, 8'h50, 0);
    chk_v("R11 directory unchanged", 4'b0100);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = RD; req_core = '0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_wake_all();
    t_nowake();
    t_wake_one();
    t_mode();
    t_nb();
    t_evict();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule